// File: doc/BRIEF.md
# Pipelined Modulo-3 Remainder Unit

This block returns the remainder of a 16-bit unsigned word divided by three, with no divider in the path, so that it keeps up with a video pixel clock. It takes one input word per clock and produces one remainder per clock. Each result arrives a fixed three cycles after its input.

The work is spread across three register stages, and each stage uses only what the stage before it registered. The first stage multiplies the word by the 16-bit fixed-point reciprocal 0x5555 and keeps the upper half of the 32-bit product as a quotient estimate. The second stage forms three times that estimate as the estimate plus the estimate shifted left by one bit. The third stage subtracts this from the original word, which has travelled alongside the pipeline. Because the reciprocal is slightly below one third, the estimate can fall one short of the true quotient. When the difference is three or more, the third stage removes three once more before it registers the result.

A qualifier travels with the data. A cycle with the input qualifier low moves a bubble through the pipeline and leaves the registered remainder untouched.

Top module: `mod3_pipe`

## Requirements
- R1: For every 16-bit input value x accepted with `in_valid` high, `out_rem` equals x mod 3, encoded as a 2-bit binary number (0, 1 or 2).
- R2: The result for an input sampled at a rising edge with `in_valid` high is registered at the second rising edge after that one. It is visible on the outputs for the whole cycle that follows. Inputs may be accepted on every cycle, one result per cycle.
- R3: `out_valid` is high in a given cycle exactly when `in_valid` was high at the sampling edge three cycles earlier, so gaps in the input stream reappear unchanged at the output.
- R4: `out_rem` never shows the value 3 (binary 11).
- R5: In a cycle with `out_valid` low, `out_rem` keeps the value of the last delivered remainder; `in_x` presented while `in_valid` is low has no effect on any later output.
- R6: While `rst_n` is low (asynchronous, active low), `out_valid` is 0 and `out_rem` is 0.
- R7: Inputs whose reciprocal estimate floor(x*0x5555/2^16) is one below floor(x/3), such as 65535, still produce the exact remainder. The uncorrected difference between x and three times the estimate never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_x` for this cycle |
| in_x | input | 16 | Unsigned dividend |
| out_valid | output | 1 | Qualifies `out_rem` |
| out_rem | output | 2 | Remainder of the dividend modulo 3 |

## Verification
Each remainder and its qualifier are due three falling edges after the falling edge at which their input was driven, one edge for each register stage. The bench keeps a three-entry history of what it drove and compares each output sample with the oldest entry, computed with the bench's own `%` operator. The sweep presents all 65,536 dividends back to back. A second phase interleaves bubbles carrying junk data with boundary values. In every bubble slot the bench expects the qualifier low and the last delivered remainder held.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  // dividend width and the fixed-point reciprocal of three at that width
  localparam int XW = 16;
  localparam int PW = 2 * XW;
  localparam int TW = XW + 2;
  localparam int RW = 2;
  localparam logic [XW-1:0] RECIP = 16'h5555;
  localparam logic [TW-1:0] THREE = TW'(3);

  typedef logic [XW-1:0] word_t;
  typedef logic [TW-1:0] triple_t;
  typedef logic [RW-1:0] rem_t;

  // upper half of x times the reciprocal: floor(x/3) or one less
  function automatic word_t quot_est(input word_t x);
    logic [PW-1:0] prod;
    prod = PW'(x) * PW'(RECIP);
    return prod[PW-1:XW];
  endfunction

  // three times q using one adder
  function automatic triple_t triple(input word_t q);
    return TW'(q) + (TW'(q) << 1);
  endfunction

  // difference before correction; only its low bits are meaningful
  function automatic triple_t raw_diff(input word_t x, input triple_t t);
    return TW'(x) - t;
  endfunction

  // one conditional subtraction of three
  function automatic rem_t fold(input triple_t raw);
    triple_t r;
    r = (raw >= THREE) ? raw - THREE : raw;
    return r[RW-1:0];
  endfunction
endpackage

// File: rtl/mod3_est_stage.sv
module mod3_est_stage
  import mod3_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  v_i,
  input  word_t x_i,
  output logic  v_o,
  output word_t x_o,
  output word_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      q_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= x_i;
        q_o <= quot_est(x_i);
      end
    end
  end
endmodule

// File: rtl/mod3_triple_stage.sv
module mod3_triple_stage
  import mod3_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    v_i,
  input  word_t   x_i,
  input  word_t   q_i,
  output logic    v_o,
  output word_t   x_o,
  output triple_t t_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      t_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= x_i;
        t_o <= triple(q_i);
      end
    end
  end
endmodule

// File: rtl/mod3_fold_stage.sv
module mod3_fold_stage
  import mod3_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    v_i,
  input  word_t   x_i,
  input  triple_t t_i,
  output triple_t raw_o,
  output logic    hit_o,
  output logic    v_o,
  output rem_t    rem_o
);
  triple_t raw;

  always_comb begin
    raw   = raw_diff(x_i, t_i);
    raw_o = raw;
    hit_o = v_i && (raw >= THREE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      rem_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) rem_o <= fold(raw);
    end
  end
endmodule

// File: rtl/mod3_pipe.sv
module mod3_pipe
  import mod3_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_x,
  output logic        out_valid,
  output logic [1:0]  out_rem
);
  logic    s1_v, s2_v;
  word_t   s1_x, s1_q, s2_x;
  triple_t s2_t;
  triple_t raw_rem;
  logic    fold_hit;

  mod3_est_stage u_est (
    .clk(clk), .rst_n(rst_n),
    .v_i(in_valid), .x_i(in_x),
    .v_o(s1_v), .x_o(s1_x), .q_o(s1_q)
  );

  mod3_triple_stage u_tri (
    .clk(clk), .rst_n(rst_n),
    .v_i(s1_v), .x_i(s1_x), .q_i(s1_q),
    .v_o(s2_v), .x_o(s2_x), .t_o(s2_t)
  );

  mod3_fold_stage u_fold (
    .clk(clk), .rst_n(rst_n),
    .v_i(s2_v), .x_i(s2_x), .t_i(s2_t),
    .raw_o(raw_rem), .hit_o(fold_hit),
    .v_o(out_valid), .rem_o(out_rem)
  );
endmodule

// File: rtl/mod3_pipe_chk.sv
module mod3_pipe_chk
  import mod3_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_x,
  input logic        out_valid,
  input logic [1:0]  out_rem,
  input logic        s2_v,
  input triple_t     raw_rem
);
  // samples taken since reset, saturating; guards every $past of depth 3
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R3
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R1
  rem_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid) |-> (32'(out_rem) == 32'($past(in_x, 3)) % 32'd3));

  // R4
  rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_rem != 2'd3);

  // R5
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !out_valid) |-> $stable(out_rem));

  // R7
  raw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |-> (raw_rem < TW'(6)));
endmodule

bind mod3_pipe mod3_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
  .out_valid(out_valid), .out_rem(out_rem),
  .s2_v(s2_v), .raw_rem(raw_rem)
);

// File: tb/tb_mod3_pipe.sv
module tb_mod3_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0;
  logic        out_valid;
  logic [1:0]  out_rem;

  int n_chk = 0;
  int n_fail = 0;
  int n_low_est = 0;

  logic        hv [3];
  logic [15:0] hx [3];
  int          last_rem = 0;

  always #5 clk = ~clk;

  mod3_pipe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_rem(out_rem)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare outputs with the input driven three falling edges ago
  task automatic check_out();
    int exp;
    int est;
    if (hv[2]) begin
      exp = int'(hx[2]) % 3;
      est = (int'(hx[2]) * 21845) >>> 16;
      chk(out_valid == 1'b1, "R2 R3 out_valid", int'(out_valid), 1);
      chk(out_rem != 2'd3, "R4 out_rem range", int'(out_rem), exp);
      if (est != int'(hx[2]) / 3) begin
        n_low_est++;
        chk(int'(out_rem) == exp, "R7 low estimate remainder", int'(out_rem), exp);
      end else begin
        chk(int'(out_rem) == exp, "R1 remainder", int'(out_rem), exp);
      end
      last_rem = exp;
    end else begin
      chk(out_valid == 1'b0, "R3 bubble out_valid", int'(out_valid), 0);
      chk(int'(out_rem) == last_rem, "R5 held out_rem", int'(out_rem), last_rem);
    end
  endtask

  task automatic cyc(input logic v, input logic [15:0] x);
    @(negedge clk);
    check_out();
    hv[2] = hv[1]; hx[2] = hx[1];
    hv[1] = hv[0]; hx[1] = hx[0];
    hv[0] = v;     hx[0] = x;
    in_valid = v;
    in_x = x;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hx[i] = '0; end
    // reset with junk stimulus on the data input
    in_x = 16'hBEEF;
    repeat (3) @(negedge clk);
    // R6
    chk(out_valid == 1'b0, "R6 reset out_valid", int'(out_valid), 0);
    chk(out_rem == 2'd0, "R6 reset out_rem", int'(out_rem), 0);
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 reset holds under in_valid", int'(out_valid), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R1 R2: every dividend back to back
    for (int x = 0; x < 65536; x++) cyc(1'b1, 16'(x));

    // R5: bubbles with junk data, interleaved with boundary dividends
    for (int k = 0; k < 12; k++) begin
      logic [15:0] b;
      case (k)
        0: b = 16'd0;     1: b = 16'd1;     2: b = 16'd2;
        3: b = 16'd3;     4: b = 16'd65535; 5: b = 16'd65534;
        6: b = 16'd65533; 7: b = 16'd49151; 8: b = 16'd32768;
        9: b = 16'd4;     10: b = 16'd21845; default: b = 16'd65532;
      endcase
      cyc(1'b1, b);
      cyc(1'b0, 16'hFFFF - 16'(k));
      if (k % 3 == 0) begin
        cyc(1'b0, 16'h1234);
        cyc(1'b0, 16'h0001);
      end
    end
    // R7: x = 65535 has a short estimate; run it in a burst
    cyc(1'b1, 16'd65535);
    cyc(1'b1, 16'd65535);
    for (int f = 0; f < 4; f++) cyc(1'b0, 16'hAAAA);
    chk(n_low_est > 0, "R7 short estimates exercised", n_low_est, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule